// File: doc/BRIEF.md
# Wake-up Timer with Absolute Alarm

This block keeps elapsed time on a slow timekeeping clock. A power-of-two prescaler divides the clock. Each prescaler terminal count advances a 47-bit count by one and also advances a modulo-60 sub-counter. Software reads the count and a 47-bit alarm value as three 16-bit slices, and it can write them as three 16-bit slices.

A control word holds three enables: run, alarm detection and alarm interrupt. While detection is enabled, the block compares the full 47-bit count with the alarm value. An exact match sets a sticky alarm flag. The interrupt output follows that flag only while both alarm enables are set. Each wrap of the modulo-60 sub-counter sets a second sticky flag. Writing 1 to a flag bit clears that flag.

When the run bit goes from 0 to 1, the prescaler and the modulo-60 sub-counter both return to phase zero. The first count increment therefore comes exactly one prescaler period after the enable.

Top module: `wkt_timer`

## Requirements
- R1: After reset, the control read-back is 3'b100 (bit 2 alarm-interrupt enable = 1, bit 1 alarm-detect enable = 0, bit 0 run = 0). Count, alarm, both flags and the interrupt are all 0.
- R2: While run is set, the count advances by one every 2^PRESC_LOG2 clock cycles. While run is clear, the count holds its value.
- R3: A control write that changes run from 0 to 1 puts the prescaler and the modulo-60 sub-counter back to phase zero. The first increment then follows exactly 2^PRESC_LOG2 cycles after that write.
- R4: The count and alarm each read as three 16-bit slices: index 0 holds bits 15:0, index 1 holds bits 31:16, and index 2 holds bits 46:32 in its bits 14:0. Bit 15 of slice 2 always reads 0, and writes to that bit are dropped.
- R5: While detection is enabled, every cycle in which all 47 count bits equal the alarm sets the alarm flag (status bit 0) at the next edge. A difference in any single bit, including bit 46, prevents a match.
- R6: While detection is disabled, the alarm flag is never set.
- R7: The interrupt output equals the alarm flag AND detect enable AND interrupt enable.
- R8: A clear write (clr_we) clears each flag whose bit in wdata is 1: bit 0 clears the alarm flag, bit 1 clears the modulo-60 flag. A flag whose bit is 0 is not affected. If a set event occurs in the same cycle as the clear, the flag stays set.
- R9: The modulo-60 flag is set on every 60th count increment after the enable.
- R10: The count wraps from all ones to zero. The wrap itself raises no flag.
- R11: A count slice write replaces that slice at the next edge. Any increment due in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timekeeping clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdata | input | 16 | Shared write data for slices, control and clear |
| ctrl_we | input | 1 | Write wdata[2:0] to the control word |
| cnt_we | input | 3 | Per-slice write strobe for the count |
| alm_we | input | 3 | Per-slice write strobe for the alarm |
| clr_we | input | 1 | Write-one-to-clear of the flags, using wdata[1:0] |
| ctrl_rd | output | 3 | Control read-back {irq_en, det_en, run} |
| cnt_rd | output | 48 | Count as three 16-bit slices |
| alm_rd | output | 48 | Alarm as three 16-bit slices |
| alarm_flag | output | 1 | Sticky alarm status |
| mod_flag | output | 1 | Sticky modulo-60 wrap status |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
A software clear of the alarm flag can land in the same cycle as a fresh alarm match. The count stays on the alarm value for a whole prescaler period, so the bench issues the clear while the match is still present and expects the flag to remain set. It then repeats the clear after the count has moved on and expects the flag to drop. A count slice write can also coincide with a prescaler terminal count. The bench writes while the timer runs and requires the written value to appear at once, and the value plus one to appear exactly one prescaler period later, whatever phase the write landed on.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  localparam int CNT_W   = 47;
  localparam int SLICE_W = 16;
  localparam int N_SLICE = 3;
  localparam int PAD_W   = N_SLICE * SLICE_W - CNT_W;
  localparam int N_FLAG  = 2;
  localparam int FL_ALARM = 0;
  localparam int FL_MOD   = 1;

  typedef struct packed {
    logic irq_en;
    logic det_en;
    logic run;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{irq_en: 1'b1, det_en: 1'b0, run: 1'b0};

  // next elapsed-time value; wraps silently
  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  // all slices of a value, unused top bits reading zero
  function automatic logic [N_SLICE*SLICE_W-1:0] to_slices(input logic [CNT_W-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  // replace one slice, dropping bits above the value width
  function automatic logic [CNT_W-1:0] put_slice(input logic [CNT_W-1:0] v,
                                                 input int idx,
                                                 input logic [SLICE_W-1:0] d);
    logic [N_SLICE*SLICE_W-1:0] p;
    p = to_slices(v);
    p[idx*SLICE_W +: SLICE_W] = d;
    return p[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/wkt_prescaler.sv
module wkt_prescaler #(
  parameter int LOG2 = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            realign,
  output logic            tick,
  output logic [LOG2-1:0] phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (realign) phase <= '0;
    else if (run)     phase <= phase + LOG2'(1);
  end

  assign tick = run && !realign && (phase == '1);
endmodule

// File: rtl/wkt_mod_counter.sv
module wkt_mod_counter #(
  parameter int MOD_N = 60,
  localparam int W = $clog2(MOD_N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         realign,
  input  logic         tick,
  output logic         wrap,
  output logic [W-1:0] val
);
  localparam logic [W-1:0] LAST = W'(MOD_N - 1);

  assign wrap = tick && (val == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       val <= '0;
    else if (realign) val <= '0;
    else if (wrap)    val <= '0;
    else if (tick)    val <= val + W'(1);
  end
endmodule

// File: rtl/wkt_sticky.sv
module wkt_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  // a set in the same cycle as a clear keeps the flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set || (q && !clr);
  end
endmodule

// File: rtl/wkt_alarm_cmp.sv
module wkt_alarm_cmp
  import wkt_pkg::*;
(
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] alarm,
  input  logic             det_en,
  output logic             match
);
  assign match = det_en && (count == alarm);
endmodule

// File: rtl/wkt_timer.sv
module wkt_timer
  import wkt_pkg::*;
#(
  parameter int PRESC_LOG2 = 2,
  parameter int MOD_N      = 60,
  localparam int MOD_W     = $clog2(MOD_N)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SLICE_W-1:0]         wdata,
  input  logic                       ctrl_we,
  input  logic [N_SLICE-1:0]         cnt_we,
  input  logic [N_SLICE-1:0]         alm_we,
  input  logic                       clr_we,
  output logic [2:0]                 ctrl_rd,
  output logic [N_SLICE*SLICE_W-1:0] cnt_rd,
  output logic [N_SLICE*SLICE_W-1:0] alm_rd,
  output logic                       alarm_flag,
  output logic                       mod_flag,
  output logic                       alarm_irq
);
  ctrl_t                ctrl_q;
  logic [CNT_W-1:0]     count_q, count_d;
  logic [CNT_W-1:0]     alarm_q, alarm_d;
  logic                 realign_w;
  logic                 tick_w;
  logic                 match_w;
  logic                 wrap_w;
  logic [PRESC_LOG2-1:0] presc_ph;
  logic [MOD_W-1:0]     mod_val;
  logic [N_FLAG-1:0]    flag_set, flag_clr, flag_q;

  // control word and start detection
  assign realign_w = ctrl_we && wdata[0] && !ctrl_q.run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (ctrl_we) ctrl_q <= ctrl_t'(wdata[2:0]);
  end

  wkt_prescaler #(.LOG2(PRESC_LOG2)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .realign(realign_w),
    .tick(tick_w), .phase(presc_ph)
  );

  wkt_mod_counter #(.MOD_N(MOD_N)) u_mod (
    .clk(clk), .rst_n(rst_n), .realign(realign_w), .tick(tick_w),
    .wrap(wrap_w), .val(mod_val)
  );

  // count: slice writes take precedence over the increment
  always_comb begin
    count_d = count_q;
    if (|cnt_we) begin
      for (int s = 0; s < N_SLICE; s++)
        if (cnt_we[s]) count_d = put_slice(count_d, s, wdata);
    end else if (tick_w) begin
      count_d = cnt_next(count_q);
    end
  end

  always_comb begin
    alarm_d = alarm_q;
    for (int s = 0; s < N_SLICE; s++)
      if (alm_we[s]) alarm_d = put_slice(alarm_d, s, wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      alarm_q <= '0;
    end else begin
      count_q <= count_d;
      alarm_q <= alarm_d;
    end
  end

  wkt_alarm_cmp u_cmp (
    .count(count_q), .alarm(alarm_q), .det_en(ctrl_q.det_en), .match(match_w)
  );

  // sticky status flags
  assign flag_set[FL_ALARM] = match_w;
  assign flag_set[FL_MOD]   = wrap_w;

  for (genvar f = 0; f < N_FLAG; f++) begin : g_flag
    assign flag_clr[f] = clr_we && wdata[f];
    wkt_sticky u_flag (
      .clk(clk), .rst_n(rst_n), .set(flag_set[f]), .clr(flag_clr[f]), .q(flag_q[f])
    );
  end

  assign alarm_flag = flag_q[FL_ALARM];
  assign mod_flag   = flag_q[FL_MOD];
  assign alarm_irq  = flag_q[FL_ALARM] && ctrl_q.det_en && ctrl_q.irq_en;

  assign ctrl_rd = ctrl_q;
  assign cnt_rd  = to_slices(count_q);
  assign alm_rd  = to_slices(alarm_q);
endmodule

// File: rtl/wkt_timer_chk.sv
module wkt_timer_chk
  import wkt_pkg::*;
#(
  parameter int PRESC_LOG2 = 2,
  parameter int MOD_N      = 60,
  localparam int MOD_W     = $clog2(MOD_N)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [SLICE_W-1:0]    wdata,
  input logic                  clr_we,
  input logic [N_SLICE-1:0]    cnt_we,
  input logic [2:0]            ctrl_rd,
  input logic                  alarm_flag,
  input logic                  alarm_irq,
  input logic                  tick_w,
  input logic                  match_w,
  input logic                  realign_w,
  input logic [PRESC_LOG2-1:0] presc_ph,
  input logic [MOD_W-1:0]      mod_val,
  input logic [CNT_W-1:0]      count_q
);
  p_tick_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_w && cnt_we == '0) |=> count_q == ($past(count_q) + CNT_W'(1)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rd[0] && cnt_we == '0) |=> $stable(count_q));

  p_realign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    realign_w |=> (presc_ph == '0 && mod_val == '0));

  p_match_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_w |=> alarm_flag);

  p_rise_needs_det_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(ctrl_rd[1]));

  p_irq_needs_det_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rd[1] |-> !alarm_irq);

  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> alarm_flag);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !(clr_we && wdata[0])) |=> alarm_flag);

  p_mod_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mod_val < MOD_W'(MOD_N));
endmodule

bind wkt_timer wkt_timer_chk #(.PRESC_LOG2(PRESC_LOG2), .MOD_N(MOD_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .wdata(wdata), .clr_we(clr_we), .cnt_we(cnt_we),
  .ctrl_rd(ctrl_rd), .alarm_flag(alarm_flag), .alarm_irq(alarm_irq),
  .tick_w(tick_w), .match_w(match_w), .realign_w(realign_w),
  .presc_ph(presc_ph), .mod_val(mod_val), .count_q(count_q)
);

// File: tb/wkt_timer_bench.sv
`timescale 1ns/1ps
module wkt_timer_bench;
  localparam int LOG2 = 2;
  localparam int DIV  = 1 << LOG2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] wdata = '0;
  logic        ctrl_we = 1'b0;
  logic [2:0]  cnt_we = '0;
  logic [2:0]  alm_we = '0;
  logic        clr_we = 1'b0;
  logic [2:0]  ctrl_rd;
  logic [47:0] cnt_rd, alm_rd;
  logic        alarm_flag, mod_flag, alarm_irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wkt_timer #(.PRESC_LOG2(LOG2), .MOD_N(60)) u_wkt_timer (
    .clk(clk), .rst_n(rst_n), .wdata(wdata), .ctrl_we(ctrl_we), .cnt_we(cnt_we),
    .alm_we(alm_we), .clr_we(clr_we), .ctrl_rd(ctrl_rd), .cnt_rd(cnt_rd),
    .alm_rd(alm_rd), .alarm_flag(alarm_flag), .mod_flag(mod_flag), .alarm_irq(alarm_irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [2:0] v);
    wdata = {13'd0, v}; ctrl_we = 1'b1;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_clr(input logic [1:0] m);
    wdata = {14'd0, m}; clr_we = 1'b1;
    @(negedge clk); clr_we = 1'b0;
  endtask

  task automatic wr_cnt(input int idx, input logic [15:0] d);
    wdata = d; cnt_we = 3'b001 << idx;
    @(negedge clk); cnt_we = '0;
  endtask

  task automatic wr_alm(input int idx, input logic [15:0] d);
    wdata = d; alm_we = 3'b001 << idx;
    @(negedge clk); alm_we = '0;
  endtask

  task automatic load(input logic [47:0] c, input logic [47:0] a);
    for (int s = 0; s < 3; s++) wr_cnt(s, c[s*16 +: 16]);
    for (int s = 0; s < 3; s++) wr_alm(s, a[s*16 +: 16]);
  endtask

  task automatic t_reset;
    chk("R1 ctrl", 64'(ctrl_rd), 64'h4);
    chk("R1 count", 64'(cnt_rd), 64'h0);
    chk("R1 alarm", 64'(alm_rd), 64'h0);
    chk("R1 flags/irq", {61'd0, alarm_flag, mod_flag, alarm_irq}, 64'h0);
  endtask

  task automatic t_count;
    wr_ctrl(3'b101);
    wait_n(DIV - 1); chk("R3 first increment not early", 64'(cnt_rd), 64'd0);
    wait_n(1);       chk("R2 first increment", 64'(cnt_rd), 64'd1);
    wait_n(3 * DIV); chk("R2 rate", 64'(cnt_rd), 64'd4);
    wr_ctrl(3'b100);
    wait_n(20);      chk("R2 hold when stopped", 64'(cnt_rd), 64'd4);
    wr_ctrl(3'b101);
    wait_n(DIV - 1); chk("R3 realigned phase", 64'(cnt_rd), 64'd4);
    wait_n(1);       chk("R3 increment after realign", 64'(cnt_rd), 64'd5);
    wr_ctrl(3'b100);
  endtask

  task automatic t_slices;
    wr_cnt(0, 16'hBEEF); wr_cnt(1, 16'h1234); wr_cnt(2, 16'hFFFF);
    chk("R4 count slices", 64'(cnt_rd), 64'h7FFF_1234_BEEF);
    wr_alm(0, 16'h00A5); wr_alm(1, 16'h5A00); wr_alm(2, 16'h8001);
    chk("R4 alarm slices", 64'(alm_rd), 64'h0001_5A00_00A5);
  endtask

  task automatic t_wrap;
    load(48'h7FFF_FFFF_FFFF, 48'h0000_0000_1234);
    wr_ctrl(3'b111);
    wait_n(DIV - 1); chk("R10 all ones", 64'(cnt_rd), 64'h7FFF_FFFF_FFFF);
    wait_n(1);       chk("R10 wraps to zero", 64'(cnt_rd), 64'h0);
    wait_n(1);       chk("R10 no flag on wrap", {62'd0, alarm_flag, mod_flag}, 64'h0);
    wr_ctrl(3'b100);
  endtask

  task automatic t_alarm;
    load(48'h0, 48'd5);
    wr_ctrl(3'b111);
    wait_n(5 * DIV);
    chk("R5 count at alarm", 64'(cnt_rd), 64'd5);
    chk("R5 flag not before match edge", 64'(alarm_flag), 64'd0);
    wait_n(1);
    chk("R5 flag on match", 64'(alarm_flag), 64'd1);
    chk("R7 irq with both enables", 64'(alarm_irq), 64'd1);
    wr_clr(2'b01);
    chk("R8 set wins over clear", 64'(alarm_flag), 64'd1);
    wait_n(DIV);
    wr_clr(2'b01);
    chk("R8 clear", 64'(alarm_flag), 64'd0);
    chk("R7 irq follows flag", 64'(alarm_irq), 64'd0);
    wr_alm(0, 16'd7);
    wait_n(DIV - 3);
    chk("R5 second match count", 64'(cnt_rd), 64'd7);
    wait_n(1);
    chk("R5 second match flag", 64'(alarm_flag), 64'd1);
    wait_n(DIV);
    wr_clr(2'b10);
    chk("R8 other mask bit keeps alarm flag", 64'(alarm_flag), 64'd1);
    wr_ctrl(3'b011);
    chk("R7 irq off without irq enable", 64'(alarm_irq), 64'd0);
    wr_ctrl(3'b101);
    chk("R7 irq off without detect", 64'(alarm_irq), 64'd0);
    chk("R7 flag kept when detect off", 64'(alarm_flag), 64'd1);
    wr_ctrl(3'b100);
    wr_clr(2'b01);
    chk("R8 cleared after stop", 64'(alarm_flag), 64'd0);
  endtask

  task automatic t_det_off;
    load(48'h0, 48'd2);
    wr_ctrl(3'b101);
    wait_n(3 * DIV);
    chk("R6 count passed alarm", 64'(cnt_rd), 64'd3);
    chk("R6 no flag without detect", {62'd0, alarm_flag, alarm_irq}, 64'h0);
    wr_ctrl(3'b100);
  endtask

  task automatic t_partial;
    load(48'h0, 48'h4000_0000_0003);
    wr_ctrl(3'b111);
    wait_n(4 * DIV);
    chk("R5 bit 46 differs, count", 64'(cnt_rd), 64'd4);
    chk("R5 bit 46 differs, no flag", 64'(alarm_flag), 64'd0);
    wr_ctrl(3'b100);
  endtask

  task automatic t_mod60;
    wr_clr(2'b11);
    load(48'h0, 48'hFFFF_FFFF);
    wr_ctrl(3'b101);
    wait_n(60 * DIV - 1);
    chk("R9 not before 60th increment", 64'(mod_flag), 64'd0);
    wait_n(1);
    chk("R9 count at 60", 64'(cnt_rd), 64'd60);
    chk("R9 flag at 60th increment", 64'(mod_flag), 64'd1);
    wr_clr(2'b10);
    chk("R8 mod flag cleared", 64'(mod_flag), 64'd0);
    wait_n(59 * DIV);
    chk("R9 next wrap count", 64'(cnt_rd), 64'd119);
    chk("R9 no flag before next wrap", 64'(mod_flag), 64'd0);
    wait_n(DIV);
    chk("R9 flag on second wrap", 64'(mod_flag), 64'd1);
    wr_ctrl(3'b100);
  endtask

  task automatic t_cntwr;
    load(48'h0, 48'hFFFF_FFFF);
    wr_ctrl(3'b101);
    wait_n(3);
    wr_cnt(0, 16'h0100);
    chk("R11 write replaces slice", 64'(cnt_rd), 64'h0100);
    wait_n(DIV);
    chk("R11 increment resumes", 64'(cnt_rd), 64'h0101);
    wr_cnt(1, 16'h0002);
    chk("R11 mid slice write", 64'(cnt_rd), 64'h0002_0101);
    wr_ctrl(3'b100);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_count();
    t_slices();
    t_wrap();
    t_alarm();
    t_det_off();
    t_partial();
    t_mod60();
    t_cntwr();
    summary();
  end
endmodule